// File: doc/BRIEF.md
# Exception Entry Sequencer

This block picks one exception out of the pending causes and performs the whole state update that starts its handler, in one entry cycle. The causes are a soft reset request, a bad opcode, a supervisor call, a fetch abort, a data abort, a normal interrupt and a fast interrupt. In the entry cycle it outputs four things at once:

- the handler address;
- the new status word;
- the pre-exception status word, to be written into the saved-status slot of the target mode;
- the return address, to be written into the link slot of the target mode.

A flush pulse tells the pipeline to discard instructions it has already fetched. The status register, the banked storage and the pipeline sit outside the block. They apply the write strobes at the clock edge that ends the entry cycle.

The sequencer is a three-state machine:

- `ST_BOOT` is held during reset. It moves unconditionally to `ST_ENTER` carrying the reset cause.
- `ST_RUN` arbitrates. It moves to `ST_ENTER` when an eligible cause is present and otherwise stays in `ST_RUN`.
- `ST_ENTER` drives the entry outputs for exactly one cycle and always returns to `ST_RUN`.

The cause, the status word, the return address and the vector-base select are all captured on the transition into `ST_ENTER`.

Top module: `exc_entry_seq`

## Requirements
- R1: In the entry cycle `pc_next` is the vector base plus an offset that depends on the cause: reset 0x00, bad opcode 0x04, supervisor call 0x08, fetch abort 0x0C, data abort 0x10, interrupt 0x18, fast interrupt 0x1C.
- R2: The low five bits of `pc_next` are never 0x14 while `pc_load` is high.
- R3: The vector base is 0x00000000 when `hi_vectors` was low at arbitration and 0xFFFF0000 when it was high.
- R4: For every cause except reset, the entry cycle raises `saved_wr` with `saved_data` equal to the status word seen at arbitration. It also raises `link_wr` with `link_data` equal to `ret_addr` seen at arbitration. Both mode outputs carry the target mode. Reset entry raises neither strobe.
- R5: Status layout: bits [4:0] are the mode, bit 5 is the compact-instruction state bit, bit 6 masks the fast interrupt and bit 7 masks the interrupt. Every entry writes the target mode, sets bit 7, clears bit 5 and keeps bits [31:8]. Mode codes: supervisor 10011 (reset and supervisor call), abort 10111 (both aborts), bad opcode 11011, interrupt 10010, fast interrupt 10001.
- R6: Fast-interrupt entry and reset entry set bit 6. Every other entry keeps bit 6 as it was.
- R7: When several causes are eligible, the winner is, from highest to lowest: reset, data abort, fast interrupt, interrupt, fetch abort, bad opcode, supervisor call.
- R8: An interrupt request is taken only while status bit 7 is clear, and a fast-interrupt request only while bit 6 is clear. A masked request produces no entry.
- R9: `pc_load`, `status_wr` and `flush` rise together for exactly one cycle, one cycle after the request is sampled. Requests present during the entry cycle are ignored.
- R10: Leaving reset performs a reset entry in the first cycle after `rst_n` rises. `req_boot` performs the same entry at any later time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_boot | input | 1 | Soft reset request |
| req_badop | input | 1 | Bad-opcode request |
| req_svc | input | 1 | Supervisor-call request |
| req_fetch_abort | input | 1 | Fetch abort request |
| req_data_abort | input | 1 | Data abort request |
| req_irq | input | 1 | Interrupt request (level) |
| req_fast | input | 1 | Fast interrupt request (level) |
| status_in | input | 32 | Current status word |
| ret_addr | input | ADDR_W | Return address for the link slot |
| hi_vectors | input | 1 | Selects the high vector base |
| pc_load | output | 1 | Load `pc_next` into the program counter |
| pc_next | output | ADDR_W | Handler address |
| status_wr | output | 1 | Write `status_next` to the status register |
| status_next | output | 32 | New status word |
| saved_wr | output | 1 | Saved-status write strobe |
| saved_mode | output | 5 | Mode whose saved-status slot is written |
| saved_data | output | 32 | Status word to save |
| link_wr | output | 1 | Link write strobe |
| link_mode | output | 5 | Mode whose link slot is written |
| link_data | output | ADDR_W | Return address to store |
| flush | output | 1 | Discard already-fetched instructions |

## Verification

The bench exercises each of the following corners and names the failure it would expose:

- **Simultaneous causes.** A data abort arriving together with a fast interrupt, and both interrupt kinds arriving together. An arbiter with a swapped priority order would vector to the wrong offset.
- **Masked interrupts.** Interrupt requests raised while their mask bits are set. A design that ignored the masks would enter anyway.
- **Held interrupt level.** A level still high after its own entry. A design that did not apply the new mask bit would enter a second time.
- **Requests during the entry cycle.** A request held only through the entry cycle must not start a second entry.
- **High vectors, the 0x14 hole and bit 6.** Random mixes with random status words check that bit 6 is kept on ordinary entries, and that a high vector base never lets the reserved offset leak out.
- **Reset entry.** A reset entry that wrote the link or saved-status slot would corrupt the supervisor-mode banked state.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int STATUS_W   = 32;
    localparam int MODE_W     = 5;
    localparam int BIT_STATE  = 5;
    localparam int BIT_FMASK  = 6;
    localparam int BIT_IMASK  = 7;
    localparam int CAUSE_W    = 3;

    // The cause code times four is the vector offset; code 5 (offset 0x14) is never used.
    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_BOOT      = 3'd0,
        CAUSE_BADOP     = 3'd1,
        CAUSE_SVCCALL   = 3'd2,
        CAUSE_FETCHERR  = 3'd3,
        CAUSE_DATAERR   = 3'd4,
        CAUSE_INTR      = 3'd6,
        CAUSE_FASTINTR  = 3'd7
    } cause_e;

    typedef enum logic [1:0] {
        ST_BOOT  = 2'd0,
        ST_RUN   = 2'd1,
        ST_ENTER = 2'd2
    } seq_state_e;

    localparam logic [MODE_W-1:0] MODE_SUPER = 5'b10011;
    localparam logic [MODE_W-1:0] MODE_ABORT = 5'b10111;
    localparam logic [MODE_W-1:0] MODE_BADOP = 5'b11011;
    localparam logic [MODE_W-1:0] MODE_INTR  = 5'b10010;
    localparam logic [MODE_W-1:0] MODE_FAST  = 5'b10001;

    function automatic logic [MODE_W-1:0] mode_of(input cause_e c);
        logic [MODE_W-1:0] m;
        unique case (c)
            CAUSE_BOOT, CAUSE_SVCCALL:     m = MODE_SUPER;
            CAUSE_FETCHERR, CAUSE_DATAERR: m = MODE_ABORT;
            CAUSE_BADOP:                   m = MODE_BADOP;
            CAUSE_INTR:                    m = MODE_INTR;
            CAUSE_FASTINTR:                m = MODE_FAST;
            default:                       m = MODE_SUPER;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
(
    input  logic   req_boot,
    input  logic   req_badop,
    input  logic   req_svc,
    input  logic   req_fetch_abort,
    input  logic   req_data_abort,
    input  logic   req_irq,
    input  logic   req_fast,
    input  logic   imask,
    input  logic   fmask,
    output logic   take,
    output cause_e cause
);
    logic irq_ok;
    logic fast_ok;

    assign irq_ok  = req_irq  && !imask;
    assign fast_ok = req_fast && !fmask;

    always_comb begin
        take  = 1'b1;
        cause = CAUSE_BOOT;
        if (req_boot)             cause = CAUSE_BOOT;
        else if (req_data_abort)  cause = CAUSE_DATAERR;
        else if (fast_ok)         cause = CAUSE_FASTINTR;
        else if (irq_ok)          cause = CAUSE_INTR;
        else if (req_fetch_abort) cause = CAUSE_FETCHERR;
        else if (req_badop)       cause = CAUSE_BADOP;
        else if (req_svc)         cause = CAUSE_SVCCALL;
        else                      take  = 1'b0;
    end
endmodule

// File: rtl/exc_vector.sv
module exc_vector
    import exc_pkg::*;
#(
    parameter int               ADDR_W  = 32,
    parameter logic [ADDR_W-1:0] HI_BASE = 32'hFFFF_0000
) (
    input  logic              hi_sel,
    input  cause_e            cause,
    output logic [ADDR_W-1:0] vec
);
    localparam int OFS_W = CAUSE_W + 2;

    logic [ADDR_W-1:0] base;
    logic [OFS_W-1:0]  ofs;

    assign base = hi_sel ? HI_BASE : '0;
    assign ofs  = {cause, 2'b00};
    assign vec  = base | ADDR_W'(ofs);
endmodule

// File: rtl/exc_status_update.sv
module exc_status_update
    import exc_pkg::*;
(
    input  logic [STATUS_W-1:0] old_status,
    input  cause_e              cause,
    output logic [STATUS_W-1:0] new_status,
    output logic [MODE_W-1:0]   target_mode
);
    always_comb begin
        target_mode            = mode_of(cause);
        new_status             = old_status;
        new_status[MODE_W-1:0] = target_mode;
        new_status[BIT_STATE]  = 1'b0;
        new_status[BIT_IMASK]  = 1'b1;
        if (cause == CAUSE_FASTINTR || cause == CAUSE_BOOT)
            new_status[BIT_FMASK] = 1'b1;
    end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_pkg::*;
#(
    parameter int               ADDR_W  = 32,
    parameter logic [ADDR_W-1:0] HI_BASE = 32'hFFFF_0000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_boot,
    input  logic                req_badop,
    input  logic                req_svc,
    input  logic                req_fetch_abort,
    input  logic                req_data_abort,
    input  logic                req_irq,
    input  logic                req_fast,
    input  logic [31:0]         status_in,
    input  logic [ADDR_W-1:0]   ret_addr,
    input  logic                hi_vectors,
    output logic                pc_load,
    output logic [ADDR_W-1:0]   pc_next,
    output logic                status_wr,
    output logic [31:0]         status_next,
    output logic                saved_wr,
    output logic [4:0]          saved_mode,
    output logic [31:0]         saved_data,
    output logic                link_wr,
    output logic [4:0]          link_mode,
    output logic [ADDR_W-1:0]   link_data,
    output logic                flush
);
    seq_state_e          state_q, state_d;
    cause_e              cause_q, arb_cause;
    logic                arb_take;
    logic [STATUS_W-1:0] old_q;
    logic [ADDR_W-1:0]   ret_q;
    logic                hi_q;
    logic [ADDR_W-1:0]   vec;
    logic [STATUS_W-1:0] upd_status;
    logic [MODE_W-1:0]   upd_mode;

    exc_arbiter u_arb (
        .req_boot        (req_boot),
        .req_badop       (req_badop),
        .req_svc         (req_svc),
        .req_fetch_abort (req_fetch_abort),
        .req_data_abort  (req_data_abort),
        .req_irq         (req_irq),
        .req_fast        (req_fast),
        .imask           (status_in[BIT_IMASK]),
        .fmask           (status_in[BIT_FMASK]),
        .take            (arb_take),
        .cause           (arb_cause)
    );

    exc_vector #(.ADDR_W(ADDR_W), .HI_BASE(HI_BASE)) u_vec (
        .hi_sel (hi_q),
        .cause  (cause_q),
        .vec    (vec)
    );

    exc_status_update u_upd (
        .old_status  (old_q),
        .cause       (cause_q),
        .new_status  (upd_status),
        .target_mode (upd_mode)
    );

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT:  state_d = ST_ENTER;
            ST_RUN:   state_d = arb_take ? ST_ENTER : ST_RUN;
            ST_ENTER: state_d = ST_RUN;
            default:  state_d = ST_RUN;
        endcase
    end

    // State register and entry capture.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_BOOT;
            cause_q <= CAUSE_BOOT;
            old_q   <= '0;
            ret_q   <= '0;
            hi_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_BOOT || (state_q == ST_RUN && arb_take)) begin
                cause_q <= (state_q == ST_BOOT) ? CAUSE_BOOT : arb_cause;
                old_q   <= status_in;
                ret_q   <= ret_addr;
                hi_q    <= hi_vectors;
            end
        end
    end

    // Outputs of the entry cycle.
    always_comb begin
        pc_load     = 1'b0;
        pc_next     = '0;
        status_wr   = 1'b0;
        status_next = '0;
        saved_wr    = 1'b0;
        saved_mode  = '0;
        saved_data  = '0;
        link_wr     = 1'b0;
        link_mode   = '0;
        link_data   = '0;
        flush       = 1'b0;
        unique case (state_q)
            ST_ENTER: begin
                pc_load     = 1'b1;
                pc_next     = vec;
                status_wr   = 1'b1;
                status_next = upd_status;
                flush       = 1'b1;
                saved_wr    = (cause_q != CAUSE_BOOT);
                saved_mode  = upd_mode;
                saved_data  = old_q;
                link_wr     = (cause_q != CAUSE_BOOT);
                link_mode   = upd_mode;
                link_data   = ret_q;
            end
            ST_BOOT, ST_RUN: ;
            default: ;
        endcase
    end
endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_irq,
    input logic              req_fast,
    input logic [31:0]       status_in,
    input logic              pc_load,
    input logic [ADDR_W-1:0] pc_next,
    input logic              status_wr,
    input logic [31:0]       status_next,
    input logic              saved_wr,
    input logic [4:0]        saved_mode,
    input logic              link_wr,
    input logic [4:0]        link_mode,
    input logic              flush
);
    AST_NO_HOLE: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> pc_next[4:0] != 5'h14); // R2

    AST_MASK_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        status_wr |-> (status_next[7] && !status_next[5])); // R5

    AST_LINK_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        link_wr |-> (link_mode == status_next[4:0] && saved_wr && saved_mode == link_mode)); // R4

    AST_IRQ_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load && pc_next[4:0] == 5'h18) |-> ($past(req_irq) && !$past(status_in[7]))); // R8

    AST_FAST_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load && pc_next[4:0] == 5'h1C) |-> ($past(req_fast) && !$past(status_in[6]) && status_next[6])); // R6

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !flush); // R9

    AST_STROBES_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        (flush == pc_load) && (pc_load == status_wr)); // R9
endmodule

bind exc_entry_seq exc_entry_seq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_exc_entry_seq.sv
module tb_exc_entry_seq;
    localparam int ADDR_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [6:0]        req = '0; // [0]boot [1]badop [2]svc [3]fetch [4]data [5]irq [6]fast
    logic [31:0]       sreg = '0;
    logic              load_req = 1'b0;
    logic [31:0]       load_val = '0;
    logic [ADDR_W-1:0] ret = '0;
    logic              hv = 1'b0;

    logic              pc_load, status_wr, saved_wr, link_wr, flush;
    logic [ADDR_W-1:0] pc_next, link_data;
    logic [31:0]       status_next, saved_data;
    logic [4:0]        saved_mode, link_mode;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    exc_entry_seq dut (
        .clk(clk), .rst_n(rst_n),
        .req_boot(req[0]), .req_badop(req[1]), .req_svc(req[2]),
        .req_fetch_abort(req[3]), .req_data_abort(req[4]),
        .req_irq(req[5]), .req_fast(req[6]),
        .status_in(sreg), .ret_addr(ret), .hi_vectors(hv),
        .pc_load(pc_load), .pc_next(pc_next),
        .status_wr(status_wr), .status_next(status_next),
        .saved_wr(saved_wr), .saved_mode(saved_mode), .saved_data(saved_data),
        .link_wr(link_wr), .link_mode(link_mode), .link_data(link_data),
        .flush(flush)
    );

    // Stand-in for the external status register.
    always @(posedge clk) begin
        if (load_req)       sreg <= load_val;
        else if (status_wr) sreg <= status_next;
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // -1 means no entry; otherwise the cause code (offset / 4).
    function automatic int exp_cause(input logic [6:0] r, input logic [31:0] s);
        if (r[0]) return 0;
        if (r[4]) return 4;
        if (r[6] && !s[6]) return 7;
        if (r[5] && !s[7]) return 6;
        if (r[3]) return 3;
        if (r[1]) return 1;
        if (r[2]) return 2;
        return -1;
    endfunction

    function automatic logic [4:0] exp_mode(input int c);
        case (c)
            0, 2: return 5'b10011;
            3, 4: return 5'b10111;
            1:    return 5'b11011;
            6:    return 5'b10010;
            default: return 5'b10001;
        endcase
    endfunction

    function automatic logic [31:0] exp_status(input int c, input logic [31:0] s);
        logic [31:0] n = s;
        n[4:0] = exp_mode(c);
        n[5] = 1'b0;
        n[7] = 1'b1;
        if (c == 7 || c == 0) n[6] = 1'b1;
        return n;
    endfunction

    task automatic set_status(input logic [31:0] v);
        @(negedge clk);
        load_req = 1'b1;
        load_val = v;
        @(negedge clk);
        load_req = 1'b0;
    endtask

    task automatic fire(input logic [6:0] r, input logic h, input logic [31:0] ra);
        int c;
        logic [31:0] s_old;
        logic [31:0] pc_exp;
        string ptag;
        @(negedge clk);
        req = r; hv = h; ret = ra;
        s_old = sreg;
        c = exp_cause(r, s_old);
        @(negedge clk);
        req = '0;
        if (c < 0) begin
            check(!flush && !pc_load && !status_wr, "R8", {29'b0, flush, pc_load, status_wr}, 32'h0);
        end else begin
            pc_exp = (h ? 32'hFFFF_0000 : 32'h0) | (c * 4);
            ptag = ($countones(r) > 1) ? "R7" : (h ? "R3" : "R1");
            check(pc_load && pc_next == pc_exp, ptag, pc_next, pc_exp);
            check(pc_next[4:0] != 5'h14, "R2", pc_next, pc_exp);
            check(flush && status_wr, "R9", {30'b0, flush, status_wr}, 32'h3);
            check(status_next[31:7] == exp_status(c, s_old)[31:7] &&
                  status_next[5:0] == exp_status(c, s_old)[5:0], "R5", status_next, exp_status(c, s_old));
            check(status_next[6] == exp_status(c, s_old)[6], "R6", {31'b0, status_next[6]}, {31'b0, exp_status(c, s_old)[6]});
            if (c == 0) begin
                check(!saved_wr && !link_wr, "R4", {30'b0, saved_wr, link_wr}, 32'h0);
            end else begin
                check(saved_wr && saved_data == s_old && saved_mode == exp_mode(c), "R4", saved_data, s_old);
                check(link_wr && link_data == ra && link_mode == exp_mode(c), "R4", link_data, ra);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        sreg = 32'h0000_00D3;
        repeat (3) @(negedge clk);
        check(!flush && !pc_load && !saved_wr && !link_wr, "R10", {28'b0, flush, pc_load, saved_wr, link_wr}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk); // first edge after release: boot -> entry
        check(pc_load && flush && pc_next == 32'h0, "R10", pc_next, 32'h0);
        check(status_next[4:0] == 5'b10011 && status_next[7] && status_next[6], "R10", status_next, 32'h0000_00D3);
        check(!saved_wr && !link_wr, "R4", {30'b0, saved_wr, link_wr}, 32'h0);
        @(negedge clk);
        check(!flush, "R9", {31'b0, flush}, 32'h0);

        // Each cause alone, masks clear.
        for (int i = 1; i < 7; i++) begin
            set_status(32'hA000_0010);
            fire(7'(1 << i), 1'b0, 32'h0000_1000 + i * 4);
        end
        set_status(32'h0000_0010);
        fire(7'b0000001, 1'b0, 32'h0);               // R10 soft reset

        // Masked interrupts produce nothing (R8).
        set_status(32'h0000_00D0);
        fire(7'b1100000, 1'b0, 32'h0);
        set_status(32'h0000_0050);
        fire(7'b1000000, 1'b0, 32'h0);
        fire(7'b1100000, 1'b0, 32'h44);              // irq taken, fast masked
        // Priority pairs (R7).
        set_status(32'h0000_0010);
        fire(7'b1100000, 1'b1, 32'h88);
        set_status(32'h0000_0010);
        fire(7'b1010000, 1'b1, 32'hCC);
        // Held irq level after its own entry is masked (R8).
        set_status(32'h0000_0010);
        fire(7'b0100000, 1'b0, 32'h10);
        fire(7'b0100000, 1'b0, 32'h14);

        // Request only during the entry cycle is ignored (R9).
        set_status(32'h0000_0010);
        @(negedge clk);
        req = 7'b0000010;
        @(negedge clk);
        check(flush, "R9", {31'b0, flush}, 32'h1);
        req = 7'b0001000;
        @(negedge clk);
        req = '0;
        check(!flush, "R9", {31'b0, flush}, 32'h0);
        @(negedge clk);
        check(!flush, "R9", {31'b0, flush}, 32'h0);

        // Constrained random mix.
        for (int k = 0; k < 60; k++) begin
            logic [6:0] r;
            r = 7'($urandom) & 7'($urandom) & 7'b1111110;
            if (($urandom % 16) == 0) r[0] = 1'b1;
            set_status($urandom);
            fire(r, 1'($urandom), $urandom);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule